// File: doc/BRIEF.md
# SDRAM Command Sequencer with Initialization Overrides

This block sits between a host memory port and an SDRAM device and converts each host request into the command sequence the device needs. In its normal setting a request becomes a row activate, a read or write, and a precharge, with the gaps between them set by three timing select bits. The sequencer also asserts a capture strobe on the cycle when read data is to be sampled.

A 3-bit mode input can replace that sequence with a single fixed command: NOP, precharge of all banks, mode register load, or auto-refresh. Firmware uses this override to step the SDRAM through its power-up sequence with ordinary host accesses. Each such access issues exactly one command and moves no data. In the mode-register setting the host address supplies the value that is loaded.

The sequencer samples the timing and mode inputs once, when it accepts a request. The host holds `req` high until `rdy` pulses, then drops it or leaves it high to ask for the next access.

Top module: `sdram_cmd_seq`

## Requirements
- R1: While reset is held and right after it, all four command pins are high (deselect), `ma` is zero, and `rdy` and `rd_capture` are low.
- R2: The pins {cs_n,ras_n,cas_n,we_n} use these encodings: NOP 0111, activate 0011, read 0101, write 0100, precharge 0010, auto-refresh 0001, mode register load 0000.
- R3: With mode 001 (NOP), 010 (precharge all) or 100 (auto-refresh), an access drives cs_n low in exactly one cycle, with the selected command. `rdy` pulses in that same cycle and `rd_capture` stays low.
- R4: Modes 101, 110 and 111 behave exactly like mode 001 and issue a single NOP.
- R5: With mode 011, an access issues one mode register load with `ma` equal to `addr[12:0]`.
- R6: The first command of an access has cs_n low in cycle L after the cycle in which the request is accepted. L is 4 when `lead_fast`=0 and 3 when it is 1. In the L-1 cycles before it, ras_n/cas_n/we_n already carry that command while cs_n stays high.
- R7: A read or write comes D+1 cycles after the activate, with D NOP cycles between them. D is 3 when `rcd_fast`=0 and 2 when it is 1.
- R8: For a read, `rd_capture` and `rdy` pulse C cycles after the read command. C is 3 when `cl_two`=0 and 2 when it is 1, plus one more when `reg_dimm`=1.
- R9: On activate, `ma` carries the row `addr[22:10]`. On read/write, `ma[9:0]` carries the column `addr[9:0]` and `ma[12:10]`=0. On precharge, `ma[10]`=1.
- R10: For a write, `rdy` pulses on the write command cycle and `rd_capture` never rises.
- R11: A precharge follows one cycle after the read capture or after the write command. The block then waits P NOP cycles before it returns to idle. P is 3 when `rp_fast`=0 and 2 when it is 1. With `req` held high, the next activate comes P+1+L cycles after the precharge.
- R12: The mode, timing, `wr` and `addr` inputs are sampled only when a request is accepted. Changing them during an access leaves that access unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 3 | Operating mode / init override select |
| cl_two | input | 1 | CAS latency select (1 = 2 clocks) |
| rcd_fast | input | 1 | Activate-to-command select (1 = 2 clocks) |
| rp_fast | input | 1 | Precharge time select (1 = 2 clocks) |
| lead_fast | input | 1 | Lead-off select (1 = 3 clocks) |
| reg_dimm | input | 1 | Registered module: one extra capture clock |
| req | input | 1 | Host access request |
| wr | input | 1 | Access is a write |
| addr | input | 23 | Host address: row [22:10], column [9:0] |
| rdy | output | 1 | Access complete pulse |
| rd_capture | output | 1 | Sample read data this cycle |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ma | output | 13 | SDRAM address |

## Verification
The bench raises `req` on a falling edge and numbers the next falling edges 1, 2, 3 and so on. The first command is due at edge L. The read or write is due at L+D+1, the capture at L+D+1+C, and the precharge one edge after the capture or write. After a precharge the next activate is due P+1+L edges later. Each scenario samples the pins on every falling edge, records the edge on which each command and strobe appears, and compares those edge numbers with the values it computes from the select bits it applied. So every result is checked at the exact cycle the sum of register stages predicts.

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq #(
  parameter int ROW_W = 13,
  parameter int COL_W = 10,
  parameter int MA_W  = 13
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [2:0]               mode,
  input  logic                     cl_two,
  input  logic                     rcd_fast,
  input  logic                     rp_fast,
  input  logic                     lead_fast,
  input  logic                     reg_dimm,
  input  logic                     req,
  input  logic                     wr,
  input  logic [ROW_W+COL_W-1:0]   addr,
  output logic                     rdy,
  output logic                     rd_capture,
  output logic                     cs_n,
  output logic                     ras_n,
  output logic                     cas_n,
  output logic                     we_n,
  output logic [MA_W-1:0]          ma
);
  localparam int HA_W = ROW_W + COL_W;
  localparam logic [3:0] C_DES = 4'b1111, C_NOP = 4'b0111, C_ACT = 4'b0011,
                         C_RD  = 4'b0101, C_WR  = 4'b0100, C_PRE = 4'b0010,
                         C_REF = 4'b0001, C_MRS = 4'b0000;
  localparam logic [MA_W-1:0] ALL_BANKS = MA_W'(1) << 10;

  typedef enum logic [2:0] {S_IDLE, S_LEAD, S_RCD, S_RW, S_DATA, S_PRE, S_RP} st_t;

  st_t             st;
  logic [2:0]      cnt;
  logic [2:0]      op_mode;
  logic            op_wr, l_cl, l_rcd, l_rp, l_reg;
  logic [HA_W-1:0] op_addr;
  logic [3:0]      first_cmd, pins;
  logic [MA_W-1:0] first_ma;
  logic            ovr;

  assign ovr = (op_mode != 3'd0);

  always_comb begin
    first_ma = '0;
    case (op_mode)
      3'd0:    begin first_cmd = C_ACT; first_ma = MA_W'(op_addr[HA_W-1:COL_W]); end
      3'd2:    begin first_cmd = C_PRE; first_ma = ALL_BANKS; end
      3'd3:    begin first_cmd = C_MRS; first_ma = op_addr[MA_W-1:0]; end
      3'd4:    first_cmd = C_REF;
      default: first_cmd = C_NOP;
    endcase
  end

  always_comb begin
    pins = C_DES;
    ma   = '0;
    case (st)
      S_LEAD:              begin pins = {cnt != 3'd0, first_cmd[2:0]}; ma = first_ma; end
      S_RCD, S_DATA, S_RP: pins = C_NOP;
      S_RW:                begin pins = op_wr ? C_WR : C_RD; ma = MA_W'(op_addr[COL_W-1:0]); end
      S_PRE:               begin pins = C_PRE; ma = ALL_BANKS; end
      default: ;
    endcase
  end

  assign {cs_n, ras_n, cas_n, we_n} = pins;
  assign rd_capture = (st == S_DATA) && (cnt == 3'd0);
  assign rdy = rd_capture || (st == S_RW && op_wr) ||
               (st == S_LEAD && cnt == 3'd0 && ovr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; op_mode <= '0; op_wr <= 1'b0; op_addr <= '0;
      l_cl <= 1'b0; l_rcd <= 1'b0; l_rp <= 1'b0; l_reg <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (req) begin
          op_mode <= mode; op_wr <= wr; op_addr <= addr;
          l_cl <= cl_two; l_rcd <= rcd_fast; l_rp <= rp_fast; l_reg <= reg_dimm;
          cnt <= lead_fast ? 3'd2 : 3'd3;
          st  <= S_LEAD;
        end
        S_LEAD:
          if (cnt != 3'd0) cnt <= cnt - 3'd1;
          else if (ovr)    st <= S_IDLE;
          else begin st <= S_RCD; cnt <= l_rcd ? 3'd1 : 3'd2; end
        S_RCD:
          if (cnt != 3'd0) cnt <= cnt - 3'd1;
          else st <= S_RW;
        S_RW:
          if (op_wr) st <= S_PRE;
          else begin st <= S_DATA; cnt <= (l_cl ? 3'd1 : 3'd2) + {2'b00, l_reg}; end
        S_DATA:
          if (cnt != 3'd0) cnt <= cnt - 3'd1;
          else st <= S_PRE;
        S_PRE: begin st <= S_RP; cnt <= l_rp ? 3'd1 : 3'd2; end
        S_RP:
          if (cnt != 3'd0) cnt <= cnt - 3'd1;
          else st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_CAPTURE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_capture |-> rdy);  // R8
  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rdy |=> !rdy);  // R3
  AST_ACT_THEN_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (pins == C_ACT) |=> (pins == C_NOP));  // R7
  AST_RW_AFTER_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (pins == C_RD || pins == C_WR) |-> ($past(pins) == C_NOP));  // R7
  AST_PRE_ALL_BANKS: assert property (@(posedge clk) disable iff (!rst_n)
    (pins == C_PRE) |-> ma[10]);  // R9
endmodule

// File: tb/sim_sdram_cmd_seq.sv
module sim_sdram_cmd_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] mode = 3'd0;
  logic cl_two = 0, rcd_fast = 0, rp_fast = 0, lead_fast = 0, reg_dimm = 0;
  logic req = 0, wr = 0;
  logic [22:0] addr = '0;
  logic rdy, rd_capture, cs_n, ras_n, cas_n, we_n;
  logic [12:0] ma;

  int n_chk = 0, n_err = 0;
  int act_k, act2_k, rw_k, cap_k, rdy_k, pre_k, cs_cnt, cap_cnt, lead_cnt, first_k;
  logic [3:0]  first_code, rw_code, lead_bits;
  logic [12:0] act_ma, rw_ma, pre_ma, first_ma;

  sdram_cmd_seq u0 (.clk, .rst_n, .mode, .cl_two, .rcd_fast, .rp_fast, .lead_fast,
    .reg_dimm, .req, .wr, .addr, .rdy, .rd_capture, .cs_n, .ras_n, .cas_n, .we_n, .ma);

  always #4 clk = ~clk;

  task automatic chk(input string r, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic run(input logic [2:0] m, input logic w, input logic [22:0] a,
                     input bit keep, input bit twist);
    logic [3:0] p;
    act_k = -1; act2_k = -1; rw_k = -1; cap_k = -1; rdy_k = -1; pre_k = -1;
    cs_cnt = 0; cap_cnt = 0; lead_cnt = 0; first_k = -1;
    lead_bits = 4'hF; first_code = 4'hF; rw_code = 4'hF;
    act_ma = '0; rw_ma = '0; pre_ma = '0; first_ma = '0;
    @(negedge clk);
    mode = m; wr = w; addr = a; req = 1'b1;
    for (int k = 1; k <= 40; k++) begin
      @(negedge clk);
      if (twist && k == 1) begin
        rcd_fast = ~rcd_fast; cl_two = ~cl_two; lead_fast = ~lead_fast;
        mode = 3'd2; wr = ~wr; addr = ~addr;
      end
      p = {cs_n, ras_n, cas_n, we_n};
      if (cs_n && p[2:0] != 3'b111 && first_k < 0) begin lead_cnt++; lead_bits = p; end
      if (!cs_n) begin
        cs_cnt++;
        if (first_k < 0) begin first_k = k; first_code = p; first_ma = ma; end
        if (p == 4'b0011) begin
          if (act_k < 0) begin act_k = k; act_ma = ma; end
          else if (act2_k < 0) act2_k = k;
        end
        if ((p == 4'b0101 || p == 4'b0100) && rw_k < 0) begin rw_k = k; rw_code = p; rw_ma = ma; end
        if (p == 4'b0010 && pre_k < 0 && act_k > 0) begin pre_k = k; pre_ma = ma; end
      end
      if (rd_capture) begin cap_cnt++; if (cap_k < 0) cap_k = k; end
      if (rdy && rdy_k < 0) begin rdy_k = k; if (!keep) req = 1'b0; end
    end
    req = 1'b0;
    repeat (30) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 pins", int'({cs_n, ras_n, cas_n, we_n}), 15);
    chk("R1 ma", int'(ma), 0);
    chk("R1 rdy", int'(rdy), 0);
    chk("R1 capture", int'(rd_capture), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pins after release", int'({cs_n, ras_n, cas_n, we_n}), 15);
  endtask

  task automatic t_read(input bit cl, input bit rcd, input bit lf, input bit rg, input bit rp);
    int L, D, C;
    logic [22:0] a;
    cl_two = cl; rcd_fast = rcd; lead_fast = lf; reg_dimm = rg; rp_fast = rp;
    L = lf ? 3 : 4; D = rcd ? 2 : 3; C = (cl ? 2 : 3) + (rg ? 1 : 0);
    a = {13'h1A5C, 10'h2B7};
    run(3'd0, 1'b0, a, 1'b0, 1'b0);
    chk("R6 activate cycle", act_k, L);
    chk("R6 lead cycles with cs_n high", lead_cnt, L - 1);
    chk("R6 lead pins carry activate", int'(lead_bits), 4'b1011);
    chk("R2 activate code", int'(first_code), 4'b0011);
    chk("R9 activate row", int'(act_ma), 13'h1A5C);
    chk("R7 read cycle", rw_k, L + D + 1);
    chk("R2 read code", int'(rw_code), 4'b0101);
    chk("R9 read column", int'(rw_ma), 10'h2B7);
    chk("R8 capture cycle", cap_k, L + D + 1 + C);
    chk("R8 ready with capture", rdy_k, L + D + 1 + C);
    chk("R8 single capture", cap_cnt, 1);
    chk("R11 precharge after capture", pre_k, L + D + 2 + C);
    chk("R9 precharge A10", int'(pre_ma[10]), 1);
  endtask

  task automatic t_write();
    cl_two = 0; rcd_fast = 1; lead_fast = 0; reg_dimm = 0; rp_fast = 0;
    run(3'd0, 1'b1, {13'h0007, 10'h3FF}, 1'b0, 1'b0);
    chk("R10 write cycle", rw_k, 4 + 2 + 1);
    chk("R2 write code", int'(rw_code), 4'b0100);
    chk("R9 write column", int'(rw_ma), 10'h3FF);
    chk("R10 ready on write", rdy_k, 7);
    chk("R10 no capture", cap_cnt, 0);
    chk("R11 precharge after write", pre_k, 8);
  endtask

  task automatic t_ovr(input logic [2:0] m, input logic [3:0] code, input string r);
    logic [22:0] a;
    lead_fast = m[0]; cl_two = 1;
    a = {10'h155, 13'h0062};
    run(m, 1'b0, a, 1'b0, 1'b0);
    chk({r, " single command"}, cs_cnt, 1);
    chk({r, " command cycle"}, first_k, m[0] ? 3 : 4);
    chk({r, " command code"}, int'(first_code), int'(code));
    chk({r, " ready cycle"}, rdy_k, first_k);
    chk({r, " no capture"}, cap_cnt, 0);
    if (m == 3'd3) chk("R5 mode register value", int'(first_ma), 13'h0062);
    if (m == 3'd2) chk("R3 precharge all A10", int'(first_ma[10]), 1);
  endtask

  task automatic t_b2b(input bit rp);
    cl_two = 1; rcd_fast = 1; lead_fast = 1; reg_dimm = 0; rp_fast = rp;
    run(3'd0, 1'b0, '0, 1'b1, 1'b0);
    chk("R11 next activate after precharge", act2_k - pre_k, (rp ? 2 : 3) + 1 + 3);
  endtask

  task automatic t_cfg_change();
    cl_two = 0; rcd_fast = 0; lead_fast = 0; reg_dimm = 0; rp_fast = 0;
    run(3'd0, 1'b0, {13'h0ABC, 10'h011}, 1'b0, 1'b1);
    chk("R12 activate unchanged", act_k, 4);
    chk("R12 read unchanged", rw_k, 8);
    chk("R12 read code unchanged", int'(rw_code), 4'b0101);
    chk("R12 column unchanged", int'(rw_ma), 10'h011);
    chk("R12 capture unchanged", cap_k, 11);
    mode = 3'd0; wr = 0;
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_read(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    t_read(1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
    t_read(1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    t_read(1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
    t_write();
    t_ovr(3'd1, 4'b0111, "R3 nop");
    t_ovr(3'd2, 4'b0010, "R3 precharge");
    t_ovr(3'd3, 4'b0000, "R5 mrs");
    t_ovr(3'd4, 4'b0001, "R3 refresh");
    t_ovr(3'd5, 4'b0111, "R4 rsv5");
    t_ovr(3'd6, 4'b0111, "R4 rsv6");
    t_ovr(3'd7, 4'b0111, "R4 rsv7");
    t_b2b(1'b0);
    t_b2b(1'b1);
    t_cfg_change();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule